// File: doc/BRIEF.md
# Systolic Global Alignment Processing Chain

The block fills one vertical slice of a global-alignment dynamic-programming matrix. A linear chain of `NPE` processing elements works along an antidiagonal wavefront. Each element owns one column of the slice. The row sequence is shifted through the chain one record per cycle. The slice's column symbols are not preloaded. They are presented on a shared bus, and each element captures its own symbol when the slice's start record reaches it.

Every slice is streamed as `m+1` records. Record 0 carries the start flag and the boundary score of matrix row 0. Records 1..m carry the row symbols. Each record brings in the left boundary score of its row. That score is either produced inside the block as `row*GAP`, for the left-most slice, or taken from the column record that an earlier slice emitted. Each record leaves the last element as a merged {symbol, score} record, ready to be fed back in for the next slice.

A per-record mode bit chooses the pointer output. In full mode every element emits its 2-bit direction pointer for every cell, for storage in parallel. In partial mode the chain instead carries a row-origin pointer, and emits it with each record of the slice's right-most column.

Top module: `sga_array`

## Requirements
- R1: While reset is asserted and until the first valid record leaves the chain, `col_vld_o`, `col_sof_o`, `rowptr_vld_o` and every bit of `dir_vld_o` are 0, and `col_rec_o` is 0.
- R2: A cell's score is the largest of three candidates. The first is the diagonal score plus the similarity, which is +2 when the two symbols are equal and +1 when they differ. The second is the score above plus the gap value −2. The third is the score to the left plus the gap value −2. Row 0 of a slice takes the left score plus the gap value.
- R3: When candidates tie, diagonal wins over upper, and upper wins over left. The pointer codes are 2'b01 for diagonal, 2'b10 for upper and 2'b11 for left. 2'b00 is never emitted with a valid flag.
- R4: Element j captures `bcast_sym` in the cycle in which the start record reaches it. That is j clock edges after the edge that samples the start record at the input. The element keeps the captured symbol for the whole slice.
- R5: In full mode (`in_mode`=0), element j raises `dir_vld_o[j]` and drives `dir_o[2j+1:2j]` once for each row 1..m, in row order. `rowptr_vld_o` stays 0 for these records.
- R6: In partial mode (`in_mode`=1), each cell inherits the row pointer of the neighbour it selected. The left boundary column of a slice carries its own row index. Row 0 carries 0. The pointer of the right-most real column is output with `rowptr_vld_o`=1, and no `dir_vld_o` bit is raised.
- R7: A record sampled at the input edge E leaves the last element at edge E+NPE−1. It leaves as `col_rec_o` = {symbol in bits [20:16], score in bits [15:0]}, with the records in input order. `col_sof_o` is high only with record 0.
- R8: With `in_gen`=1 the left boundary score of row i is i×(−2). With `in_gen`=0 it is `in_score`, for example a column record fed back from the previous slice.
- R9: An element whose captured symbol is the null code 0 passes the score and row pointer through unchanged and raises no `dir_vld_o`. A slice narrower than the chain therefore outputs its last real column.
- R10: Cycles with `in_vld`=0 leave every element's state unchanged, so idle gaps inside a slice do not alter any result.
- R11: A new slice's start record may directly follow the previous slice's last record, with no flush. Its outputs then follow on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input record valid |
| in_sof | input | 1 | Input record is the slice start (row 0) |
| in_mode | input | 1 | 0 = full direction pointers, 1 = partial row pointers |
| in_gen | input | 1 | 1 = generate the left boundary score internally |
| in_sym | input | 5 | Shifted row symbol (0 = null) |
| in_score | input | 16 | Left boundary score fed in from outside |
| bcast_sym | input | 5 | Broadcast column symbol bus |
| col_vld_o | output | 1 | Column record valid at the chain end |
| col_sof_o | output | 1 | Column record is row 0 of its slice |
| col_rec_o | output | 21 | Merged {symbol, score} of the right-most column |
| rowptr_vld_o | output | 1 | Row pointer valid (partial mode) |
| rowptr_o | output | 16 | Row-origin pointer of the right-most column |
| dir_vld_o | output | 8 | Per-element direction pointer valid |
| dir_o | output | 16 | Per-element 2-bit direction pointers |

## Verification
The chain is driven with a left-most slice in full mode. That pattern separates the score recurrence, the similarity lookup and the per-element pointer order from the boundary generation. A partial-mode pair of slices, the second fed with the first's captured column records, shows that feedback and row-pointer inheritance agree with an independent reference matrix. A narrow slice padded with null columns and interleaved with idle cycles separates transparent elements and held state from real computation. Back-to-back slices and two identical uniform sequences, which create many diagonal/upper and diagonal/left ties, show the lack of a flush and the tie priority.

// File: rtl/sga_pkg.sv
package sga_pkg;
   // Direction pointer codes; a downstream traceback decodes these values.
   typedef enum logic [1:0] {
      DIR_NONE = 2'b00,
      DIR_DIAG = 2'b01,
      DIR_UP   = 2'b10,
      DIR_LEFT = 2'b11
   } dir_e;
endpackage

// File: rtl/sga_feed.sv
// Front end: numbers the rows of each slice and optionally generates the
// left boundary score as row*GAP for the left-most slice.
module sga_feed #(
   parameter int SC_W = 16,
   parameter int RP_W = 16,
   parameter int GAP  = -2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vld_i,
   input  logic                   sof_i,
   input  logic                   gen_i,
   input  logic signed [SC_W-1:0] sc_i,
   output logic signed [SC_W-1:0] sc_o,
   output logic [RP_W-1:0]        rp_o
);
   localparam logic signed [SC_W-1:0] GAP_S = SC_W'(GAP);

   logic [RP_W-1:0]        cnt_q, idx;
   logic signed [SC_W-1:0] acc_q, gsc;

   always_comb begin
      idx  = sof_i ? '0 : cnt_q;
      gsc  = sof_i ? '0 : acc_q;
      sc_o = gen_i ? gsc : sc_i;
      rp_o = idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         acc_q <= '0;
      end else if (vld_i) begin
         cnt_q <= idx + RP_W'(1);
         acc_q <= gsc + GAP_S;
      end
   end
endmodule

// File: rtl/sga_pe.sv
// One column of the wavefront: captures its column symbol on the slice
// start record and evaluates one cell per valid incoming row record.
module sga_pe
   import sga_pkg::*;
#(
   parameter int SYM_W = 5,
   parameter int SC_W  = 16,
   parameter int RP_W  = 16,
   parameter int MATCH = 2,
   parameter int MISM  = 1,
   parameter int GAP   = -2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SYM_W-1:0]       bsym_i,
   input  logic                   vld_i,
   input  logic                   sof_i,
   input  logic                   mode_i,
   input  logic [SYM_W-1:0]       sym_i,
   input  logic signed [SC_W-1:0] sc_i,
   input  logic [RP_W-1:0]        rp_i,
   output logic                   vld_o,
   output logic                   sof_o,
   output logic                   mode_o,
   output logic [SYM_W-1:0]       sym_o,
   output logic signed [SC_W-1:0] sc_o,
   output logic [RP_W-1:0]        rp_o,
   output logic [1:0]             dir_o,
   output logic                   dvld_o
);
   localparam logic signed [SC_W-1:0] MATCH_S = SC_W'(MATCH);
   localparam logic signed [SC_W-1:0] MISM_S  = SC_W'(MISM);
   localparam logic signed [SC_W-1:0] GAP_S   = SC_W'(GAP);

   logic [SYM_W-1:0]       col_q, csym;
   logic signed [SC_W-1:0] up_sc_q, dg_sc_q, cd, cu, cl, sim, h_n;
   logic [RP_W-1:0]        up_rp_q, dg_rp_q, rp_n;
   dir_e                   dir_n;
   logic                   live;

   always_comb begin
      csym = sof_i ? bsym_i : col_q;
      live = (csym != '0);
      sim  = (csym == sym_i) ? MATCH_S : MISM_S;
      cd   = dg_sc_q + sim;
      cu   = up_sc_q + GAP_S;
      cl   = sc_i + GAP_S;
      if (!live) begin
         h_n = sc_i;  rp_n = rp_i;    dir_n = DIR_NONE;
      end else if (sof_i) begin
         h_n = cl;    rp_n = rp_i;    dir_n = DIR_NONE;
      end else if (cd >= cu && cd >= cl) begin
         h_n = cd;    rp_n = dg_rp_q; dir_n = DIR_DIAG;
      end else if (cu >= cl) begin
         h_n = cu;    rp_n = up_rp_q; dir_n = DIR_UP;
      end else begin
         h_n = cl;    rp_n = rp_i;    dir_n = DIR_LEFT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q   <= '0;
         up_sc_q <= '0;
         up_rp_q <= '0;
         dg_sc_q <= '0;
         dg_rp_q <= '0;
         vld_o   <= 1'b0;
         sof_o   <= 1'b0;
         mode_o  <= 1'b0;
         sym_o   <= '0;
         sc_o    <= '0;
         rp_o    <= '0;
         dir_o   <= DIR_NONE;
         dvld_o  <= 1'b0;
      end else begin
         vld_o  <= vld_i;
         dvld_o <= vld_i & live & ~sof_i & ~mode_i;
         if (vld_i) begin
            col_q   <= csym;
            up_sc_q <= h_n;
            up_rp_q <= rp_n;
            dg_sc_q <= sc_i;
            dg_rp_q <= rp_i;
            sof_o   <= sof_i;
            mode_o  <= mode_i;
            sym_o   <= sym_i;
            sc_o    <= h_n;
            rp_o    <= rp_n;
            dir_o   <= dir_n;
         end
      end
   end
endmodule

// File: rtl/sga_array.sv
module sga_array #(
   parameter int NPE   = 8,
   parameter int SYM_W = 5,
   parameter int SC_W  = 16,
   parameter int RP_W  = 16,
   parameter int MATCH = 2,
   parameter int MISM  = 1,
   parameter int GAP   = -2,
   localparam int REC_W = SYM_W + SC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic               in_sof,
   input  logic               in_mode,
   input  logic               in_gen,
   input  logic [SYM_W-1:0]   in_sym,
   input  logic [SC_W-1:0]    in_score,
   input  logic [SYM_W-1:0]   bcast_sym,
   output logic               col_vld_o,
   output logic               col_sof_o,
   output logic [REC_W-1:0]   col_rec_o,
   output logic               rowptr_vld_o,
   output logic [RP_W-1:0]    rowptr_o,
   output logic [NPE-1:0]     dir_vld_o,
   output logic [2*NPE-1:0]   dir_o
);
   if (NPE < 1)      $error("sga_array: NPE must be at least 1");
   if (SYM_W < 2)    $error("sga_array: SYM_W must be at least 2");
   if (SC_W < 4)     $error("sga_array: SC_W too narrow");
   if (RP_W < 2)     $error("sga_array: RP_W too narrow");
   if (GAP >= 0)     $error("sga_array: GAP must be a penalty");
   if (MATCH < MISM) $error("sga_array: MATCH must not be below MISM");

   logic                   vld_c  [NPE+1];
   logic                   sof_c  [NPE+1];
   logic                   mode_c [NPE+1];
   logic [SYM_W-1:0]       sym_c  [NPE+1];
   logic signed [SC_W-1:0] sc_c   [NPE+1];
   logic [RP_W-1:0]        rp_c   [NPE+1];

   assign vld_c[0]  = in_vld;
   assign sof_c[0]  = in_sof;
   assign mode_c[0] = in_mode;
   assign sym_c[0]  = in_sym;

   sga_feed #(.SC_W(SC_W), .RP_W(RP_W), .GAP(GAP)) u_feed (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_vld),
      .sof_i (in_sof),
      .gen_i (in_gen),
      .sc_i  (in_score),
      .sc_o  (sc_c[0]),
      .rp_o  (rp_c[0])
   );

   for (genvar j = 0; j < NPE; j++) begin : g_pe
      sga_pe #(
         .SYM_W(SYM_W), .SC_W(SC_W), .RP_W(RP_W),
         .MATCH(MATCH), .MISM(MISM), .GAP(GAP)
      ) u_pe (
         .clk    (clk),
         .rst_n  (rst_n),
         .bsym_i (bcast_sym),
         .vld_i  (vld_c[j]),
         .sof_i  (sof_c[j]),
         .mode_i (mode_c[j]),
         .sym_i  (sym_c[j]),
         .sc_i   (sc_c[j]),
         .rp_i   (rp_c[j]),
         .vld_o  (vld_c[j+1]),
         .sof_o  (sof_c[j+1]),
         .mode_o (mode_c[j+1]),
         .sym_o  (sym_c[j+1]),
         .sc_o   (sc_c[j+1]),
         .rp_o   (rp_c[j+1]),
         .dir_o  (dir_o[2*j +: 2]),
         .dvld_o (dir_vld_o[j])
      );
   end

   assign col_vld_o    = vld_c[NPE];
   assign col_sof_o    = vld_c[NPE] & sof_c[NPE];
   assign col_rec_o    = {sym_c[NPE], sc_c[NPE]};
   assign rowptr_vld_o = vld_c[NPE] & mode_c[NPE];
   assign rowptr_o     = rowptr_vld_o ? rp_c[NPE] : '0;
endmodule

// File: rtl/sga_chk.sv
module sga_chk #(
   parameter int NPE  = 8,
   parameter int SC_W = 16,
   parameter int RP_W = 16,
   parameter int GAP  = -2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             col_vld_o,
   input logic             col_sof_o,
   input logic [SC_W-1:0]  col_sc,
   input logic             rowptr_vld_o,
   input logic [RP_W-1:0]  rowptr_o,
   input logic [NPE-1:0]   dir_vld_o,
   input logic [2*NPE-1:0] dir_o
);
   logic [RP_W-1:0]        row_q, row_cur;
   logic signed [SC_W-1:0] last_q;
   logic                   seen_q;
   logic signed [SC_W:0]   cur_w, lim_w;

   always_comb begin
      row_cur = col_sof_o ? '0 : row_q;
      cur_w   = {col_sc[SC_W-1], col_sc};
      lim_w   = {last_q[SC_W-1], last_q} + (SC_W+1)'(GAP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         last_q <= '0;
         seen_q <= 1'b0;
      end else if (col_vld_o) begin
         row_q  <= row_cur + RP_W'(1);
         last_q <= col_sc;
         seen_q <= 1'b1;
      end
   end

   for (genvar j = 0; j < NPE; j++) begin : g_dir
      // R3: a valid pointer is always one of the three move codes
      p_dir_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
         dir_vld_o[j] |-> dir_o[2*j +: 2] != 2'b00);
   end

   // R6: a row pointer only travels with a column record
   p_rp_with_rec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rowptr_vld_o |-> col_vld_o);

   // R6: row 0 of a slice always points at row 0
   p_rp_row0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rowptr_vld_o && col_sof_o) |-> rowptr_o == '0);

   // R6: a path cannot originate below the row it reaches
   p_rp_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rowptr_vld_o |-> rowptr_o <= row_cur);

   // R2: down a column the score never falls by more than one gap
   p_score_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (col_vld_o && !col_sof_o && seen_q) |-> cur_w >= lim_w);
endmodule

bind sga_array sga_chk #(.NPE(NPE), .SC_W(SC_W), .RP_W(RP_W), .GAP(GAP)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .col_vld_o    (col_vld_o),
   .col_sof_o    (col_sof_o),
   .col_sc       (col_rec_o[SC_W-1:0]),
   .rowptr_vld_o (rowptr_vld_o),
   .rowptr_o     (rowptr_o),
   .dir_vld_o    (dir_vld_o),
   .dir_o        (dir_o)
);

// File: tb/sga_array_test.sv
`timescale 1ns/1ps
module sga_array_test;
   localparam int NPE = 8, SYM_W = 5, SC_W = 16, RP_W = 16;
   localparam int GAP = -2, MATCH = 2, MISM = 1;
   localparam int REC_W = SYM_W + SC_W;
   localparam int NS = 256;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, in_vld, in_sof, in_mode, in_gen;
   logic [SYM_W-1:0] in_sym, bcast_sym;
   logic [SC_W-1:0]  in_score;
   logic col_vld_o, col_sof_o, rowptr_vld_o;
   logic [REC_W-1:0] col_rec_o;
   logic [RP_W-1:0]  rowptr_o;
   logic [NPE-1:0]   dir_vld_o;
   logic [2*NPE-1:0] dir_o;

   sga_array #(.NPE(NPE), .SYM_W(SYM_W), .SC_W(SC_W), .RP_W(RP_W),
               .MATCH(MATCH), .MISM(MISM), .GAP(GAP)) uut (.*);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   int A [1:24];
   int B [0:16];
   int H [0:16][0:24];
   int D [0:16][0:24];
   int R [0:16][0:24];
   int fb [0:16];

   bit s_vld [NS]; bit s_sof [NS]; bit s_mode [NS]; bit s_gen [NS];
   int s_sym [NS]; int s_sc [NS]; int s_bc [NS];

   int c_n; int c_sc [128]; int c_sym [128]; bit c_sof [128];
   bit c_rpv [128]; int c_rp [128]; int c_t [128];
   int d_n [NPE]; int d_v [NPE][64];

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sim(int a, int b);
      return (a == b) ? MATCH : MISM;
   endfunction

   task automatic model(int m, int n);
      for (int j = 0; j <= n; j++) begin H[0][j] = j * GAP; D[0][j] = 0; end
      for (int i = 1; i <= m; i++) begin
         H[i][0] = i * GAP; D[i][0] = 0;
         for (int j = 1; j <= n; j++) begin
            int cd, cu, cl;
            cd = H[i-1][j-1] + sim(A[j], B[i]);
            cu = H[i-1][j] + GAP;
            cl = H[i][j-1] + GAP;
            if (cd >= cu && cd >= cl) begin H[i][j] = cd; D[i][j] = 1; end
            else if (cu >= cl)        begin H[i][j] = cu; D[i][j] = 2; end
            else                      begin H[i][j] = cl; D[i][j] = 3; end
         end
      end
   endtask

   task automatic rp_model(int m, int c0, int n);
      for (int i = 0; i <= m; i++) R[i][c0] = i;
      for (int j = c0 + 1; j <= n; j++) begin
         R[0][j] = 0;
         for (int i = 1; i <= m; i++)
            R[i][j] = (D[i][j] == 1) ? R[i-1][j-1] :
                      (D[i][j] == 2) ? R[i-1][j] : R[i][j-1];
      end
   endtask

   task automatic clear_stim();
      for (int t = 0; t < NS; t++) begin
         s_vld[t] = 0; s_sof[t] = 0; s_mode[t] = 0; s_gen[t] = 0;
         s_sym[t] = 0; s_sc[t] = 0; s_bc[t] = 0;
      end
   endtask

   // src: 0 generated boundary, 1 reference column, 2 captured feedback
   task automatic add_slice(int t0, int m, int c0, int w, int src, bit mode,
                            int gap_every, output int tend);
      int t;
      t = t0;
      for (int k = 0; k <= m; k++) begin
         s_vld[t] = 1; s_sof[t] = (k == 0); s_mode[t] = mode;
         s_gen[t] = (src == 0);
         s_sym[t] = (k == 0) ? 0 : B[k];
         s_sc[t]  = (src == 1) ? H[k][c0] : (src == 2) ? fb[k] : 0;
         t++;
         if (gap_every > 0 && (k % gap_every) == gap_every - 1) t += 2;
      end
      for (int j = 0; j < NPE; j++) s_bc[t0 + j] = (j < w) ? A[c0 + j + 1] : 0;
      tend = t;
   endtask

   task automatic play(int T);
      c_n = 0;
      for (int j = 0; j < NPE; j++) d_n[j] = 0;
      for (int t = 0; t < T; t++) begin
         @(negedge clk);
         if (col_vld_o) begin
            c_sc[c_n]  = int'($signed(col_rec_o[SC_W-1:0]));
            c_sym[c_n] = int'(col_rec_o[REC_W-1:SC_W]);
            c_sof[c_n] = col_sof_o;
            c_rpv[c_n] = rowptr_vld_o;
            c_rp[c_n]  = int'(rowptr_o);
            c_t[c_n]   = t;
            c_n++;
         end
         for (int j = 0; j < NPE; j++)
            if (dir_vld_o[j]) begin
               d_v[j][d_n[j]] = int'(dir_o[2*j +: 2]);
               d_n[j]++;
            end
         in_vld    = (t < NS) ? s_vld[t] : 1'b0;
         in_sof    = (t < NS) ? s_sof[t] : 1'b0;
         in_mode   = (t < NS) ? s_mode[t] : 1'b0;
         in_gen    = (t < NS) ? s_gen[t] : 1'b0;
         in_sym    = (t < NS) ? SYM_W'(s_sym[t]) : '0;
         in_score  = (t < NS) ? SC_W'(s_sc[t]) : '0;
         bcast_sym = (t < NS) ? SYM_W'(s_bc[t]) : '0;
      end
   endtask

   task automatic check_col(int base, int m, int c0, int w, bit mode, string req);
      check(c_n >= base + m + 1, req, "record count", c_n, base + m + 1);
      for (int k = 0; k <= m && base + k < c_n; k++) begin
         int x;
         x = base + k;
         check(c_sc[x] == H[k][c0 + w], req, $sformatf("score row %0d", k),
               c_sc[x], H[k][c0 + w]);
         if (k > 0) check(c_sym[x] == B[k], "R7", $sformatf("symbol row %0d", k),
                          c_sym[x], B[k]);
         check(c_sof[x] == (k == 0), "R7", $sformatf("start flag row %0d", k),
               int'(c_sof[x]), int'(k == 0));
         check(c_rpv[x] == mode, mode ? "R6" : "R5", "row pointer valid",
               int'(c_rpv[x]), int'(mode));
         if (mode) check(c_rp[x] == R[k][c0 + w], "R6",
                         $sformatf("row pointer row %0d", k), c_rp[x], R[k][c0 + w]);
      end
   endtask

   task automatic check_dir(int off, int m, int c0, int w, string req);
      for (int j = 0; j < NPE; j++) begin
         if (j < w) begin
            check(d_n[j] >= off + m, req, $sformatf("pointer count pe %0d", j),
                  d_n[j], off + m);
            for (int i = 1; i <= m && off + i - 1 < d_n[j]; i++)
               check(d_v[j][off+i-1] == D[i][c0+j+1], "R3",
                     $sformatf("pointer pe %0d row %0d", j, i),
                     d_v[j][off+i-1], D[i][c0+j+1]);
         end
      end
   endtask

   task automatic set_seqs();
      for (int j = 1; j <= 24; j++) A[j] = (j * 5 + 1) % 7 + 1;
      B[0] = 0;
      for (int i = 1; i <= 16; i++) B[i] = (i * 3 + 2) % 7 + 1;
   endtask

   task automatic t_reset();
      rst_n = 0; in_vld = 0; in_sof = 0; in_mode = 0; in_gen = 0;
      in_sym = '0; in_score = '0; bcast_sym = '0;
      repeat (3) @(negedge clk);
      check(col_vld_o == 0 && col_sof_o == 0, "R1", "column valid in reset",
            int'(col_vld_o), 0);
      check(rowptr_vld_o == 0 && dir_vld_o == '0, "R1", "pointer valids in reset",
            int'(dir_vld_o), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      check(col_rec_o == '0 && col_vld_o == 0, "R1", "record after release",
            int'(col_rec_o), 0);
   endtask

   task automatic t_full_first();
      int te;
      set_seqs(); model(6, 16);
      clear_stim(); add_slice(0, 6, 0, 8, 0, 0, 0, te);
      play(te + NPE + 4);
      check(c_n > 0 && c_t[0] == NPE, "R7", "chain latency", c_n > 0 ? c_t[0] : -1, NPE);
      check_col(0, 6, 0, 8, 0, "R2");
      check_dir(0, 6, 0, 8, "R5");
   endtask

   task automatic t_partial_feedback();
      int te;
      set_seqs(); model(7, 16);
      rp_model(7, 0, 16);
      clear_stim(); add_slice(0, 7, 0, 8, 0, 1, 0, te);
      play(te + NPE + 4);
      check_col(0, 7, 0, 8, 1, "R6");
      for (int j = 0; j < NPE; j++)
         check(d_n[j] == 0, "R6", $sformatf("no pointers pe %0d", j), d_n[j], 0);
      for (int k = 0; k <= 7; k++) fb[k] = (k < c_n) ? c_sc[k] : 0;
      rp_model(7, 8, 16);
      clear_stim(); add_slice(0, 7, 8, 8, 2, 1, 0, te);
      play(te + NPE + 4);
      check_col(0, 7, 8, 8, 1, "R8");
   endtask

   task automatic t_null_gaps();
      int te;
      set_seqs(); model(6, 16);
      clear_stim(); add_slice(0, 6, 0, 5, 0, 0, 2, te);
      play(te + NPE + 4);
      check_col(0, 6, 0, 5, 0, "R10");
      check_dir(0, 6, 0, 5, "R10");
      for (int j = 5; j < NPE; j++)
         check(d_n[j] == 0, "R9", $sformatf("null pe %0d silent", j), d_n[j], 0);
      check(c_n > 6 && c_sc[6] == H[6][5], "R9", "narrow slice last column",
            c_n > 6 ? c_sc[6] : -999, H[6][5]);
   endtask

   task automatic t_back_to_back();
      int te, te2;
      set_seqs(); model(8, 16);
      clear_stim();
      add_slice(0, 8, 0, 8, 0, 0, 0, te);
      add_slice(te, 8, 8, 8, 1, 0, 0, te2);
      play(te2 + NPE + 4);
      check(c_n == 18, "R11", "records of two slices", c_n, 18);
      check_col(0, 8, 0, 8, 0, "R11");
      check_col(9, 8, 8, 8, 0, "R11");
      check_dir(0, 8, 0, 8, "R11");
      check_dir(8, 8, 8, 8, "R11");
      check(c_n == 18 && c_t[9] == c_t[8] + 1, "R11", "no bubble between slices",
            c_n == 18 ? c_t[9] - c_t[8] : -1, 1);
   endtask

   task automatic t_ties();
      int te, ties;
      for (int j = 1; j <= 24; j++) A[j] = 5;
      B[0] = 0;
      for (int i = 1; i <= 16; i++) B[i] = 5;
      model(6, 16);
      clear_stim(); add_slice(0, 6, 0, 8, 0, 0, 0, te);
      play(te + NPE + 4);
      ties = 0;
      for (int i = 1; i <= 6; i++)
         for (int j = 1; j <= 8; j++) begin
            int cd, cu, cl;
            cd = H[i-1][j-1] + sim(A[j], B[i]);
            cu = H[i-1][j] + GAP;
            cl = H[i][j-1] + GAP;
            if (cd == H[i][j] && (cd == cu || cd == cl)) begin
               ties++;
               if (i - 1 < d_n[j-1])
                  check(d_v[j-1][i-1] == 1, "R3",
                        $sformatf("tie resolved to diagonal r%0d c%0d", i, j),
                        d_v[j-1][i-1], 1);
            end
         end
      check(ties > 0, "R3", "tie cells present", ties, 1);
      check_col(0, 6, 0, 8, 0, "R2");
      check_dir(0, 6, 0, 8, "R4");
   endtask

   initial begin
      t_reset();
      t_full_first();
      t_partial_feedback();
      t_null_gaps();
      t_back_to_back();
      t_ties();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule